// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces the periodic interrupt of a real-time clock. It runs from a 32.768 kHz enable strobe and takes two fields from the control registers: a rate code and a periodic-interrupt enable bit. While it is enabled and the rate code is non-zero, it counts strobes. Each time the count reaches the selected period it raises a one-cycle flag-set pulse and a one-cycle interrupt request.

The register file owns the periodic flag. It sets the flag on `flag_set_o` and clears it when software reads the status register. The schedule restarts whenever the rate code changes, and when control register B is written with the enable bit set. After a restart, a full period passes before the first event.

Top module: `pirq_rate_gen`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs are low after that edge, and the period count returns to zero.
- R2: With the enable high and a steady rate code r from 1 to 15, events repeat every 2^(r-1) ticks of `tick_i`. This gives a rate of 32768 >> (r-1) Hz.
- R3: Rate code 0 produces no events.
- R4: While `pie_i` is low, no event is produced, and the count is held at zero.
- R5: Each event raises `flag_set_o` and `irq_o` together for exactly one clock cycle. When the period is 2 or more ticks, both outputs are low between events.
- R6: A change of `rate_sel_i` restarts the count. The first event at the new rate is visible on the outputs 2^(r-1)+1 clock edges after the first edge that sees the new code (strobe every clock).
- R7: A one-cycle `wr_b_i` strobe while `pie_i` is high restarts the count with the same timing as R6.
- R8: Only clock cycles with `tick_i` high advance the count. With no strobes there are no events. With a strobe every k clocks, the event spacing is k·2^(r-1) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | 32.768 kHz enable strobe, one clock wide |
| rate_sel_i | input | 4 | Rate code: 0 = off, r = period of 2^(r-1) ticks |
| pie_i | input | 1 | Periodic interrupt enable bit |
| wr_b_i | input | 1 | One-cycle strobe marking a write to control register B |
| flag_set_o | output | 1 | One-cycle pulse that sets the periodic flag |
| irq_o | output | 1 | One-cycle interrupt request per event |

## Verification
The bench builds the block with its default rate field of 4 bits. This gives a 15-bit count, so every rate code from 1 to 15 is legal. The bench mostly drives the strobe on every clock, so even the slowest period of 16384 ticks is measured exactly within the run. A divided strobe and a stopped strobe separate tick counting from clock counting. Restarts are triggered in mid-period, so an early or late first event shows up as a wrong edge count.

// File: rtl/pirq_pkg.sv
// Shared types for the periodic interrupt rate generator.
// Assumes: one clock domain; all users import this package.
package pirq_pkg;

    // Control decisions handed from the restart logic to the counter.
    typedef struct packed {
        logic active;   // enable high and rate code non-zero
        logic restart;  // clear the schedule this cycle
    } pirq_ctl_t;

endpackage

// File: rtl/pirq_rate_decode.sv
// Turns a rate code into the terminal count of the period counter.
// Code r >= 1 gives terminal 2^(r-1)-1. Code 0 is reported as invalid.
// Assumes: CNT_W >= maximum code - 1, so the terminal always fits.
module pirq_rate_decode #(
    parameter int RATE_W = 4,
    parameter int CNT_W  = (1 << RATE_W) - 1
) (
    input  logic [RATE_W-1:0] rate_i,
    output logic [CNT_W-1:0]  term_o,
    output logic              valid_o
);

    // Bit i of the terminal is set whenever i lies below r-1.
    for (genvar i = 0; i < CNT_W; i++) begin : g_term
        assign term_o[i] = (32'(rate_i) > (i + 1));
    end

    // A zero code turns periodic events off.
    assign valid_o = (rate_i != '0);

endmodule

// File: rtl/pirq_restart_ctl.sv
// Decides when the period schedule is live and when it must restart.
// A restart follows a change of the rate code, or a register-B write
// with the enable bit set.
// Assumes: wr_b_i is one clock wide per register write.
module pirq_restart_ctl
    import pirq_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              valid_i,
    input  logic              pie_i,
    input  logic              wr_b_i,
    output pirq_ctl_t         ctl_o
);

    logic [RATE_W-1:0] rate_q;

    // Holds last cycle's rate code so that changes can be detected.
    always_ff @(posedge clk) begin
        if (!rst_n) rate_q <= '0;
        else        rate_q <= rate_i;
    end

    // Combines enable, code validity and restart causes.
    always_comb begin
        ctl_o.active  = pie_i && valid_i;
        ctl_o.restart = (rate_i != rate_q) || (wr_b_i && pie_i);
    end

endmodule

// File: rtl/pirq_period_cnt.sv
// Counts timebase ticks up to the terminal count and emits a registered
// one-cycle event on the tick that completes a period.
// Assumes: term_i is stable unless ctl_i.restart is raised with it.
module pirq_period_cnt
    import pirq_pkg::*;
#(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  pirq_ctl_t        ctl_i,
    input  logic [CNT_W-1:0] term_i,
    output logic             evt_o
);

    logic [CNT_W-1:0] cnt_q;

    // Advances the period count on ticks and flags the terminal tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            evt_o <= 1'b0;
        end else begin
            evt_o <= 1'b0;
            if (!ctl_i.active || ctl_i.restart) begin
                cnt_q <= '0;
            end else if (tick_i) begin
                if (cnt_q == term_i) begin
                    cnt_q <= '0;
                    evt_o <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R2: the count never passes the selected terminal value.
    a_r2_cnt_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_i.restart |-> (cnt_q <= term_i));

    // R6: a restart leaves the count at zero on the next cycle.
    a_r6_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_i.restart |=> (cnt_q == '0));

    // R8: a cycle without a tick never produces an event.
    a_r8_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> !evt_o);

endmodule

// File: rtl/pirq_rate_gen.sv
// Top of the periodic interrupt rate generator. It decodes the rate code,
// manages restarts and counts 32.768 kHz ticks. Each completed period
// gives one flag-set pulse and one interrupt request pulse.
// Assumes: tick_i is a one-clock strobe; the register file owns the flag.
module pirq_rate_gen
    import pirq_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic [RATE_W-1:0] rate_sel_i,
    input  logic              pie_i,
    input  logic              wr_b_i,
    output logic              flag_set_o,
    output logic              irq_o
);

    localparam int CNT_W = (1 << RATE_W) - 1;

    logic [CNT_W-1:0] term;
    logic             code_ok;
    pirq_ctl_t        ctl;
    logic             evt;

    pirq_rate_decode #(.RATE_W(RATE_W), .CNT_W(CNT_W)) u_decode (
        .rate_i  (rate_sel_i),
        .term_o  (term),
        .valid_o (code_ok)
    );

    pirq_restart_ctl #(.RATE_W(RATE_W)) u_restart (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_i  (rate_sel_i),
        .valid_i (code_ok),
        .pie_i   (pie_i),
        .wr_b_i  (wr_b_i),
        .ctl_o   (ctl)
    );

    pirq_period_cnt #(.CNT_W(CNT_W)) u_count (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_i),
        .ctl_i  (ctl),
        .term_i (term),
        .evt_o  (evt)
    );

    // Flag-set pulse straight from the registered event.
    assign flag_set_o = evt;

    // Interrupt request pulse, suppressed whenever the enable is low.
    assign irq_o = evt && pie_i;

    // R3: a zero rate code yields no flag pulse on the next cycle.
    a_r3_zero_code_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (rate_sel_i == '0) |=> !flag_set_o);

    // R4: a low enable yields no flag pulse on the next cycle.
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !pie_i |=> !flag_set_o);

    // R1: outputs are low in the cycle after a reset edge.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!flag_set_o && !irq_o));

endmodule

// File: tb/tb_pirq_rate_gen.sv
`timescale 1ns/1ps
module tb_pirq_rate_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [3:0] rate = 4'd0;
    logic       pie = 1'b0;
    logic       wr_b = 1'b0;
    logic       flag_set;
    logic       irq;

    int total = 0;
    int bad = 0;
    int tick_div = 1;
    int tick_cnt = 0;

    pirq_rate_gen dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .rate_sel_i (rate),
        .pie_i      (pie),
        .wr_b_i     (wr_b),
        .flag_set_o (flag_set),
        .irq_o      (irq)
    );

    always #2 clk = ~clk;

    // Timebase strobe, one in tick_div clocks; 0 stops it.
    always @(negedge clk) begin
        if (tick_div == 0) begin
            tick = 1'b0;
            tick_cnt = 0;
        end else if (tick_cnt >= tick_div - 1) begin
            tick = 1'b1;
            tick_cnt = 0;
        end else begin
            tick = 1'b0;
            tick_cnt++;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Negedges until irq is seen high; wr_b is dropped after the first.
    task automatic wait_irq(input int limit, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            @(negedge clk);
            wr_b = 1'b0;
            if (irq) begin
                n = i;
                break;
            end
        end
    endtask

    // Number of negedges with irq or flag high over a window.
    task automatic count_pulses(input int len, output int n);
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            wr_b = 1'b0;
            if (irq || flag_set) n++;
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        check("R1 irq in reset", int'(irq), 0);
        check("R1 flag in reset", int'(flag_set), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq after reset", int'(irq), 0);
    endtask

    // Restart at rate r via a B write, then check first event, spacing, width.
    task automatic t_rate(input int r);
        int n;
        int per;
        per = 1 << (r - 1);
        @(negedge clk);
        rate = 4'(r);
        pie = 1'b1;
        wr_b = 1'b1;
        wait_irq(40000, n);
        check($sformatf("R6 first event rate %0d", r), n, per + 1);
        wait_irq(40000, n);
        check($sformatf("R2 spacing rate %0d", r), n, per);
        check($sformatf("R5 flag with irq rate %0d", r), int'(flag_set), 1);
        if (per >= 2) begin
            @(negedge clk);
            check($sformatf("R5 pulse width rate %0d", r), int'(irq || flag_set), 0);
        end
    endtask

    task automatic t_change();
        int n;
        t_rate(5);
        repeat (3) @(negedge clk);
        rate = 4'd3;
        wait_irq(1000, n);
        check("R6 restart on code change", n, 5);
    endtask

    task automatic t_bwrite();
        int n;
        t_rate(4);
        repeat (4) @(negedge clk);
        wr_b = 1'b1;
        wait_irq(1000, n);
        check("R7 restart on B write", n, 9);
    endtask

    task automatic t_disable();
        int n;
        t_rate(2);
        pie = 1'b0;
        count_pulses(60, n);
        check("R4 no events with enable low", n, 0);
    endtask

    task automatic t_zero_code();
        int n;
        @(negedge clk);
        pie = 1'b1;
        rate = 4'd0;
        wr_b = 1'b1;
        count_pulses(200, n);
        check("R3 no events with code 0", n, 0);
    endtask

    task automatic t_ticks();
        int n;
        tick_div = 3;
        @(negedge clk);
        rate = 4'd3;
        pie = 1'b1;
        wait_irq(1000, n);
        wait_irq(1000, n);
        check("R8 spacing with strobe every 3 clocks", n, 12);
        tick_div = 0;
        count_pulses(300, n);
        check("R8 no events without strobe", n, 0);
        tick_div = 1;
    endtask

    initial begin
        #(200000 * 4);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_rate(1);
        t_rate(2);
        t_rate(3);
        t_rate(6);
        t_rate(15);
        t_change();
        t_bwrite();
        t_disable();
        t_zero_code();
        t_ticks();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule